// File: doc/BRIEF.md
# I2C Slave 8-Bit Port Expander

This block is an I2C bus slave that converts between the serial bus and an 8-bit bidirectional parallel port. A free-running system clock oversamples SCL and SDA. The block recognizes START and STOP conditions and its own address, and it takes part in the bus only by enabling an open-drain pull on SDA. It never stretches the clock.

A write transfer first programs a per-pin direction mask. Every byte after that replaces the output value register. Pins configured as outputs drive that register, and the other pins stay high-impedance.

A read transfer snapshots the port once per byte and shifts the snapshot to the master, most significant bit first. The same bitstream is copied onto a dedicated serial output pin, which sits at 0 whenever no read data is moving. Three strap inputs set the low address bits, so up to eight of these blocks can share one bus.

Top module: `i2c_port_expander`

## Requirements
- R1: The block acknowledges only the 7-bit address whose upper four bits are 0111 and whose lower three bits equal `sel_i`. On any other address it does not pull SDA, ignores every later bit, and leaves all registers unchanged until the next START.
- R2: The block pulls SDA low during the 9th clock of the matching address byte and of every write byte. It changes its SDA drive only after a detected SCL falling edge, or on START or STOP.
- R3: The first byte after a write address (R/W bit 0) is loaded into the direction register. A bit value of 1 makes the pin an output (`port_oe_o` bit = 1), and 0 makes it an input.
- R4: Every later byte of the same write transfer overwrites the output register, so the last byte wins. `port_out_o` shows the register, and a pin is driven only where its direction bit is 1.
- R5: With R/W bit 1, the port is captured on the 8th SCL falling edge of every byte, including the address byte. Each capture is sent, MSB first, in the byte that follows. A 0 bit pulls SDA and a 1 bit releases it.
- R6: For a pin set as an output, the captured and reported bit is the value that pin drives, not the pin input.
- R7: During the data bits of a read byte, `mirror_o` equals the bit placed on SDA. At all other times it is 0.
- R8: After reset, the direction and output registers are 0, and SDA and `mirror_o` are released and low. A pin later switched to output drives 0 until a data byte is written.
- R9: When the master does not acknowledge a read byte, the block releases SDA and stays silent for any further clocks until the next START.
- R10: A START at any point restarts address reception, and a STOP returns the block to idle. Neither changes the direction or output registers, and a partly received byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull_o | output | 1 | 1 enables the open-drain pull of SDA to 0 |
| sel_i | input | 3 | Strap levels matched against the low address bits |
| port_in_i | input | 8 | Sampled levels of the parallel pins |
| port_oe_o | output | 8 | Per-pin output enable (direction register) |
| port_out_o | output | 8 | Per-pin drive value (output register) |
| mirror_o | output | 1 | Copy of the read bitstream, 0 otherwise |

## Verification
The bench checks that an output pin reports its own drive value in a read. A design that sampled the pin input there would return the wrong bits for mixed direction masks.

It changes the port inside a read byte, before its 8th falling edge. A design that captured once per transfer, or that shifted out the live capture, would return the same value twice or the new value too early.

A master NACK is followed by extra clocks, which catches a block that keeps driving SDA. A wrong strap address is followed by data, which catches a block that writes registers anyway.

A repeated START is issued in the middle of a data byte. A design that committed partial bytes, or that reset its registers on START, would show changed outputs afterwards.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } link_st_t;

  // Value reported for the port: outputs read back their drive value.
  function automatic logic [BYTE_W-1:0] port_view(input logic [BYTE_W-1:0] dir,
                                                  input logic [BYTE_W-1:0] drv,
                                                  input logic [BYTE_W-1:0] pins);
    return (dir & drv) | (~dir & pins);
  endfunction

  // Bit transmitted after cnt bits of a byte have already gone out.
  function automatic logic tx_bit(input logic [BYTE_W-1:0] b, input logic [CNT_W-1:0] cnt);
    return b[3'(BYTE_W - 1 - int'(cnt))];
  endfunction
endpackage

// File: rtl/pexp_sync.sv
module pexp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {WIDTH{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pexp_cond.sv
module pexp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pexp_link.sv
module pexp_link import pexp_pkg::*; #(
  parameter int SEL_W = 3,
  parameter int FIX_W = BYTE_W - 1 - SEL_W,
  parameter logic [FIX_W-1:0] ADDR_HI = 4'b0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [SEL_W-1:0]  strap,
  input  logic [BYTE_W-1:0] cap_q,
  output logic              sda_pull,
  output logic              mirror,
  output logic              wr_dir_en,
  output logic              wr_out_en,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              cap_en
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  link_st_t          st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rd_q;
  logic              dir_next_q;
  logic              mack_q;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] frame, input logic [SEL_W-1:0] s);
    return frame[BYTE_W-1:1] == {ADDR_HI, s};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      rd_q       <= 1'b0;
      dir_next_q <= 1'b0;
      mack_q     <= 1'b0;
      sda_pull   <= 1'b0;
      wr_dir_en  <= 1'b0;
      wr_out_en  <= 1'b0;
      cap_en     <= 1'b0;
    end else begin
      wr_dir_en <= 1'b0;
      wr_out_en <= 1'b0;
      cap_en    <= 1'b0;
      if (start_det) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (addr_hit(shreg, strap)) begin
                st       <= ST_AACK;
                sda_pull <= 1'b1;
                rd_q     <= shreg[0];
                cap_en   <= shreg[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_q) begin
                st       <= ST_RDATA;
                sda_pull <= ~cap_q[BYTE_W-1];
              end else begin
                st         <= ST_WDATA;
                sda_pull   <= 1'b0;
                dir_next_q <= 1'b1;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              st         <= ST_WACK;
              sda_pull   <= 1'b1;
              wr_dir_en  <= dir_next_q;
              wr_out_en  <= ~dir_next_q;
              dir_next_q <= 1'b0;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              st       <= ST_WDATA;
              sda_pull <= 1'b0;
              cnt      <= '0;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                st       <= ST_RACK;
                sda_pull <= 1'b0;
                cap_en   <= 1'b1;
              end else begin
                sda_pull <= ~tx_bit(cap_q, cnt);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                st       <= ST_RDATA;
                cnt      <= '0;
                sda_pull <= ~cap_q[BYTE_W-1];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_byte = shreg;
  assign mirror  = (st == ST_RDATA) & ~sda_pull;

  // R2: the SDA drive moves only after an SCL fall or a bus condition
  p_pull_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det));
  // R7: the mirror pin is active only inside a read transfer
  p_mirror_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mirror |-> rd_q);
  // R10: STOP leaves the bus released and the engine idle
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> (st == ST_IDLE) && !sda_pull);
  // R10: START always restarts address reception
  p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR) && (cnt == '0) && !sda_pull);
  // R9: master NACK ends the read
  p_nack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK) && scl_fall && !mack_q && !start_det && !stop_det |=> st == ST_IDLE);
  // R3: a byte commits to one register only
  p_commit_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_dir_en && wr_out_en));
endmodule

// File: rtl/pexp_regs.sv
module pexp_regs import pexp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_dir_en,
  input  logic              wr_out_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] pins,
  output logic [BYTE_W-1:0] dir_q,
  output logic [BYTE_W-1:0] out_q,
  output logic [BYTE_W-1:0] cap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      cap_q <= '0;
    end else begin
      if (wr_dir_en) dir_q <= wr_byte;
      if (wr_out_en) out_q <= wr_byte;
      if (cap_en)    cap_q <= port_view(dir_q, out_q, pins);
    end
  end

  // R3: direction changes only on a committed first write byte
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_q) |-> $past(wr_dir_en));
  // R4: output value changes only on a committed data byte
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(wr_out_en));
  // R6: captured bits of output pins equal their drive value
  p_cap_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> ((cap_q ^ $past(out_q)) & $past(dir_q)) == '0);
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander import pexp_pkg::*; #(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-2-SEL_W:0] ADDR_HI = 4'b0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] port_in_i,
  output logic [BYTE_W-1:0] port_oe_o,
  output logic [BYTE_W-1:0] port_out_o,
  output logic              mirror_o
);
  localparam int FIX_W = BYTE_W - 1 - SEL_W;

  logic [1:0]        bus_s;
  logic [BYTE_W-1:0] pins_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_dir_en, wr_out_en, cap_en;
  logic [BYTE_W-1:0] wr_byte, cap_q;

  pexp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

  pexp_sync #(.WIDTH(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(port_in_i), .q(pins_s));

  pexp_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  pexp_link #(.SEL_W(SEL_W), .FIX_W(FIX_W), .ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_s(bus_s[0]), .strap(sel_i), .cap_q(cap_q),
    .sda_pull(sda_pull_o), .mirror(mirror_o),
    .wr_dir_en(wr_dir_en), .wr_out_en(wr_out_en),
    .wr_byte(wr_byte), .cap_en(cap_en));

  pexp_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_dir_en(wr_dir_en), .wr_out_en(wr_out_en), .wr_byte(wr_byte),
    .cap_en(cap_en), .pins(pins_s),
    .dir_q(port_oe_o), .out_q(port_out_o), .cap_q(cap_q));
endmodule

// File: tb/sim_i2c_port_expander.sv
module sim_i2c_port_expander;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 6;
  localparam int H  = 12;
  localparam int WD = 150000;

  // {sel, dir, out, pins}
  localparam logic [31:0] VEC [6] = '{
    32'h05_00_A5_3C, 32'h00_FF_5A_C3, 32'h07_0F_96_F0,
    32'h02_F0_69_0F, 32'h03_81_FF_00, 32'h06_3C_00_FF };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [2:0] sel = 3'd5;
  logic [7:0] pins = 8'h00;
  logic sda_pull, mirror;
  logic [7:0] oe, drv;
  logic sda_line;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_pull;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_port_expander u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .sel_i(sel), .port_in_i(pins), .port_oe_o(oe), .port_out_o(drv), .mirror_o(mirror));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic write_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
  endtask

  task automatic read_bit(output logic v, output logic m);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(H/2); v = sda_line; m = mirror;
    tick(H/2); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic v, m;
    for (int i = 7; i >= 0; i--) write_bit(b[i]);
    read_bit(v, m);
    acked = ~v;
  endtask

  // swap pins to newp after four bits when swap is set
  task automatic recv_byte(input bit give_ack, input bit swap, input logic [7:0] newp,
                           output logic [7:0] b, output bit mir_ok);
    logic v, m;
    mir_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      read_bit(v, m);
      b[i] = v;
      if (m !== v) mir_ok = 1'b0;
      if (swap && i == 4) pins = newp;
    end
    write_bit(~give_ack);
  endtask

  function automatic logic [7:0] expect_view(input logic [7:0] d, input logic [7:0] o, input logic [7:0] p);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[i] ? o[i] : p[i];
    return r;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {4'b0111, s, rd};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", WD);
      finish_run();
    end
  end

  initial begin
    bit ak, mok;
    logic [7:0] rb, rb2, e;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R8 reset state
    check(oe == 8'h00, "R8 reset oe", oe, 0);
    check(drv == 8'h00, "R8 reset out", drv, 0);
    check(!sda_pull && !mirror, "R8 reset sda/mirror", {sda_pull, mirror}, 0);

    // R8 switch to output before any data: drives 0
    bus_start();
    send_byte(addr_byte(3'd5, 1'b0), ak); check(ak, "R1 addr ack", ak, 1);
    send_byte(8'hFF, ak); check(ak, "R2 dir ack", ak, 1);
    bus_stop();
    check(oe == 8'hFF, "R3 dir loaded", oe, 8'hFF);
    check(drv == 8'h00, "R8 output starts at 0", drv, 0);

    // Vector table
    foreach (VEC[k]) begin
      logic [2:0] vs; logic [7:0] vd, vo, vp;
      vs = VEC[k][26:24]; vd = VEC[k][23:16]; vo = VEC[k][15:8]; vp = VEC[k][7:0];
      sel = vs; pins = vp;
      bus_start();
      send_byte(addr_byte(vs, 1'b0), ak); check(ak, "R1 addr ack", ak, 1);
      send_byte(vd, ak); check(ak, "R2 dir ack", ak, 1);
      send_byte(vo, ak); check(ak, "R2 data ack", ak, 1);
      bus_stop();
      check(oe == vd, "R3 direction", oe, vd);
      check(drv == vo, "R4 output value", drv, vo);
      check(mirror == 1'b0, "R7 mirror low after write", mirror, 0);
      e = expect_view(vd, vo, vp);
      bus_start();
      send_byte(addr_byte(vs, 1'b1), ak); check(ak, "R1 read addr ack", ak, 1);
      recv_byte(1'b1, 1'b0, 8'h00, rb, mok);
      check(rb == e, "R5 R6 read byte", rb, e);
      check(mok, "R7 mirror follows sda", mok, 1);
      recv_byte(1'b0, 1'b0, 8'h00, rb2, mok);
      check(rb2 == e, "R5 second read byte", rb2, e);
      bus_stop();
      check(mirror == 1'b0, "R7 mirror low after read", mirror, 0);
    end

    // R4 several data bytes, last wins
    sel = 3'd5;
    bus_start();
    send_byte(addr_byte(3'd5, 1'b0), ak);
    send_byte(8'h0F, ak);
    send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h37, ak);
    check(ak, "R2 ack on later byte", ak, 1);
    bus_stop();
    check(oe == 8'h0F && drv == 8'h37, "R4 last byte wins", {oe, drv}, 16'h0F37);

    // R1 address mismatch: no ack, bytes ignored
    bus_start();
    send_byte(addr_byte(3'd2, 1'b0), ak); check(!ak, "R1 mismatch no ack", ak, 0);
    send_byte(8'hAA, ak); check(!ak, "R1 ignored byte no ack", ak, 0);
    send_byte(8'h55, ak);
    bus_stop();
    check(oe == 8'h0F && drv == 8'h37, "R1 regs unchanged", {oe, drv}, 16'h0F37);

    // R5 capture per byte at the 8th fall
    bus_start();
    send_byte(addr_byte(3'd5, 1'b0), ak); send_byte(8'h00, ak);
    bus_stop();
    pins = 8'h11;
    bus_start();
    send_byte(addr_byte(3'd5, 1'b1), ak);
    recv_byte(1'b1, 1'b1, 8'h22, rb, mok);
    check(rb == 8'h11, "R5 first byte from address capture", rb, 8'h11);
    recv_byte(1'b0, 1'b0, 8'h00, rb2, mok);
    check(rb2 == 8'h22, "R5 second byte from 8th fall capture", rb2, 8'h22);

    // R9 after NACK the block stays silent
    begin
      logic v, m; bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 9; i++) begin
        read_bit(v, m);
        if (v !== 1'b1 || m !== 1'b0) quiet = 1'b0;
      end
      check(quiet, "R9 silent after nack", quiet, 1);
    end
    bus_stop();

    // R10 repeated START mid data byte: partial byte dropped, regs kept
    pins = 8'hC6;
    bus_start();
    send_byte(addr_byte(3'd5, 1'b0), ak); send_byte(8'hAA, ak);
    send_byte(8'h3C, ak);
    write_bit(1'b1); write_bit(1'b1); write_bit(1'b0); write_bit(1'b0);
    bus_start();
    send_byte(addr_byte(3'd5, 1'b1), ak); check(ak, "R10 restart addr ack", ak, 1);
    e = expect_view(8'hAA, 8'h3C, 8'hC6);
    recv_byte(1'b0, 1'b0, 8'h00, rb, mok);
    check(rb == e, "R10 read after restart", rb, e);
    bus_stop();
    check(oe == 8'hAA && drv == 8'h3C, "R10 regs kept", {oe, drv}, 16'hAA3C);

    done = 1'b1;
    finish_run();
  end
endmodule